// File: doc/BRIEF.md
# I2C SCL rate divider

This block turns the system clock into the bit timing used by an I2C byte engine. A 7-bit rate byte holds a linear divisor M in its upper four bits and an exponent N in its lower three bits. Two counters in cascade produce a one-cycle timing tick. The first is a prescaler that wraps every M+1 clocks. The second is a power-of-two stage that wraps every 2^(N+1) prescaler wraps, or every 2^N wraps when the alternate power mode is selected. The SCL phase output is high for five ticks and then low for five ticks, so SCL runs at Fsys / (10·(M+1)·2^(N+1)).

A written rate byte, and the power-mode select, wait in a pending register. They take over only when a full SCL period ends, at the low-to-high step of the phase, so no shortened half-period is ever produced. A hold input lets the engine stretch the low half while another device keeps SCL low. While the phase is high, the hold input has no effect. A soft reset returns the rate to its power-on value of 0x44 (M=8, N=4) and restarts the period.

Top module: `i2c_rate_gen`

## Requirements
- R1: After reset, scl_phase is 1, tick is 0, and the active rate is 0x44, so ticks are spaced 9·32 = 288 clock cycles apart.
- R2: With pow_alt=0, ticks are spaced (M+1)·2^(N+1) cycles apart. M is taken from cfg_wdata[6:3] and N from cfg_wdata[2:0].
- R3: With pow_alt=1, ticks are spaced (M+1)·2^N cycles apart. For M=0 and N=0 this means a tick on every cycle.
- R4: scl_phase holds each level for exactly 5 ticks, so a full SCL period is 10 ticks. It changes only in the cycle after a tick, or after a soft reset.
- R5: A rate written with cfg_we, and the level of pow_alt, take effect only at the end of the current SCL period. The half-periods already in progress keep their old length.
- R6: While scl_hold=1 and scl_phase=0, both counters freeze and tick stays 0. Each held cycle adds one cycle to the low half.
- R7: While scl_phase=1, scl_hold has no effect on timing.
- R8: A one-cycle soft_rst pulse restores the rate to 0x44 and pow_alt mode 0, and clears the counters. In the next cycle scl_phase is 1 and tick is 0, and ticks are then spaced 288 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous restore of the default rate and restart of the period |
| cfg_we | input | 1 | Write strobe for the pending rate byte |
| cfg_wdata | input | 7 | Rate byte: M in bits 6:3, N in bits 2:0 |
| pow_alt | input | 1 | Power-stage select, sampled at each period end: 0 gives 2^(N+1), 1 gives 2^N |
| scl_hold | input | 1 | Freezes the timing while the SCL phase is low |
| tick | output | 1 | One-cycle pulse at ten times the SCL rate |
| scl_phase | output | 1 | Current SCL level: 1 for the high half, 0 for the low half |

## Verification
The tick spacing is measured for rate bytes that vary only M, only N, both at their maximum, and both at zero. This separates a swapped field split, an off-by-one in either counter, and a wrong exponent offset. The same bytes are measured in both power modes, which shows whether the exponent shifts by one. The lengths of the high and low halves are measured separately: around a mid-period rate write, to show when the new rate takes over, and with a hold applied in each half, to show that only the low half stretches and that it stretches by exactly the number of held cycles. A soft reset issued from a fast rate is followed by a spacing of 288 cycles.

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int M_W        = 4,
  parameter int N_W        = 3,
  parameter int HALF_TICKS = 5,
  parameter logic [M_W+N_W-1:0] RST_BAUD = 7'h44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               cfg_we,
  input  logic [M_W+N_W-1:0] cfg_wdata,
  input  logic               pow_alt,
  input  logic               scl_hold,
  output logic               tick,
  output logic               scl_phase
);
  localparam int BAUD_W = M_W + N_W;
  localparam int POW_W  = 1 << N_W;
  localparam int PH_W   = $clog2(2 * HALF_TICKS);

  logic [BAUD_W-1:0] pend_q, act_q;
  logic              alt_q;
  logic [M_W-1:0]    pre_q;
  logic [POW_W-1:0]  pow_q;
  logic [PH_W-1:0]   ph_q;

  wire [M_W-1:0]   m_val  = act_q[BAUD_W-1:N_W];
  wire [N_W-1:0]   n_val  = act_q[N_W-1:0];
  wire [N_W:0]     shamt  = {1'b0, n_val} + {{N_W{1'b0}}, ~alt_q};
  wire [POW_W:0]   span   = {{POW_W{1'b0}}, 1'b1} << shamt;
  wire [POW_W:0]   span_m = span - {{POW_W{1'b0}}, 1'b1};
  wire [POW_W-1:0] lim    = span_m[POW_W-1:0];

  assign scl_phase = ph_q < PH_W'(HALF_TICKS);

  wire frozen  = scl_hold && !scl_phase;
  wire pre_end = pre_q == m_val;
  wire pow_end = pow_q == lim;
  assign tick  = !frozen && pre_end && pow_end;
  wire bound   = tick && (ph_q == PH_W'(2 * HALF_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_BAUD;
      act_q  <= RST_BAUD;
      alt_q  <= 1'b0;
      pre_q  <= '0;
      pow_q  <= '0;
      ph_q   <= '0;
    end else if (soft_rst) begin
      pend_q <= RST_BAUD;
      act_q  <= RST_BAUD;
      alt_q  <= 1'b0;
      pre_q  <= '0;
      pow_q  <= '0;
      ph_q   <= '0;
    end else begin
      if (cfg_we) pend_q <= cfg_wdata;
      if (!frozen) begin
        pre_q <= pre_end ? '0 : pre_q + 1'b1;
        if (pre_end) pow_q <= pow_end ? '0 : pow_q + 1'b1;
        if (tick) ph_q <= bound ? '0 : ph_q + 1'b1;
      end
      if (bound) begin
        act_q <= pend_q;
        alt_q <= pow_alt;
      end
    end
  end
endmodule

// File: rtl/i2c_rate_gen_chk.sv
module i2c_rate_gen_chk #(
  parameter int HALF_TICKS = 5
) (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic scl_hold,
  input logic tick,
  input logic scl_phase
);
  logic       prev_q, skip_q;
  logic [7:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      skip_q <= 1'b0;
      tcnt_q <= '0;
    end else begin
      prev_q <= scl_phase;
      skip_q <= soft_rst;
      if (soft_rst)
        tcnt_q <= '0;
      else if (scl_phase != prev_q)
        tcnt_q <= tick ? 8'd1 : 8'd0;
      else if (tick && tcnt_q != 8'hFF)
        tcnt_q <= tcnt_q + 8'd1;
    end
  end

  // R4
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip_q && scl_phase != prev_q) |-> tcnt_q == 8'(HALF_TICKS));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_phase) |-> ($past(tick) || $past(soft_rst)));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !scl_phase && !soft_rst) |=> $stable(scl_phase));

  // R8
  soft_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (scl_phase && !tick));
endmodule

bind i2c_rate_gen i2c_rate_gen_chk #(.HALF_TICKS(HALF_TICKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .scl_hold(scl_hold), .tick(tick), .scl_phase(scl_phase)
);

// File: tb/i2c_rate_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic pow_alt = 1'b0;
  logic scl_hold = 1'b0;
  logic tick, scl_phase;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pow_alt(pow_alt), .scl_hold(scl_hold),
    .tick(tick), .scl_phase(scl_phase)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_tick(output int n);
    do @(negedge clk); while (!tick);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
  endtask

  task automatic measure_level(input bit lvl, output int n);
    do @(negedge clk); while (scl_phase == lvl);
    do @(negedge clk); while (scl_phase != lvl);
    n = 1;
    forever begin
      @(negedge clk);
      if (scl_phase == lvl) n++; else break;
    end
  endtask

  task automatic apply(input logic [6:0] b, input bit alt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = b; pow_alt = alt;
    @(negedge clk);
    cfg_we = 1'b0;
    do @(negedge clk); while (scl_phase);
    do @(negedge clk); while (!scl_phase);
  endtask

  task automatic t_reset();
    int n;
    check("R1 scl_phase after reset", int'(scl_phase), 1);
    check("R1 tick after reset", int'(tick), 0);
    measure_tick(n);
    check("R1 default spacing", n, 288);
  endtask

  task automatic t_rate();
    int n;
    apply(7'h00, 1'b0); measure_tick(n); check("R2 M0 N0", n, 2);
    apply(7'h0B, 1'b0); measure_tick(n); check("R2 M1 N3", n, 32);
    measure_level(1'b1, n); check("R4 high half M1 N3", n, 160);
    measure_level(1'b0, n); check("R4 low half M1 N3", n, 160);
    apply(7'h78, 1'b0); measure_tick(n); check("R2 M15 N0", n, 32);
    apply(7'h05, 1'b0); measure_tick(n); check("R2 M0 N5", n, 64);
    apply(7'h7F, 1'b0); measure_tick(n); check("R2 M15 N7", n, 4096);
  endtask

  task automatic t_alt();
    int n;
    apply(7'h00, 1'b1); measure_tick(n); check("R3 M0 N0 alt", n, 1);
    measure_level(1'b0, n); check("R4 low half at tick per cycle", n, 5);
    apply(7'h13, 1'b1); measure_tick(n); check("R3 M2 N3 alt", n, 24);
    apply(7'h13, 1'b0); measure_tick(n); check("R3 M2 N3 normal", n, 48);
  endtask

  task automatic t_boundary();
    int n;
    apply(7'h0B, 1'b0);
    repeat (20) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 7'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    measure_level(1'b0, n); check("R5 low half keeps old rate", n, 160);
    measure_level(1'b1, n); check("R5 next high uses new rate", n, 10);
  endtask

  task automatic t_hold(input bit lvl, input int exp, input string req);
    int n;
    int tk;
    tk = 0;
    do @(negedge clk); while (scl_phase == lvl);
    do @(negedge clk); while (scl_phase != lvl);
    n = 1;
    forever begin
      if (n == 3) scl_hold = 1'b1;
      if (n == 10) scl_hold = 1'b0;
      @(negedge clk);
      if (scl_hold && tick) tk++;
      if (scl_phase == lvl) n++; else break;
    end
    scl_hold = 1'b0;
    check(req, n, exp);
    if (!lvl) check("R6 no tick while held low", tk, 0);
  endtask

  task automatic t_soft();
    int n;
    apply(7'h00, 1'b0);
    repeat (3) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R8 scl_phase after soft reset", int'(scl_phase), 1);
    check("R8 tick after soft reset", int'(tick), 0);
    measure_tick(n);
    check("R8 spacing after soft reset", n, 288);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate();
    t_alt();
    t_boundary();
    apply(7'h0B, 1'b0);
    t_hold(1'b0, 167, "R6 low half stretched by hold");
    t_hold(1'b1, 160, "R7 high half ignores hold");
    t_soft();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule